// File: doc/BRIEF.md
# CRC-Guarded Serial Register Port

This block is the peripheral side of a four-wire serial link that gives an external host access to an on-chip register file. Each transaction is one fixed 32-bit frame clocked in SPI mode 0. The host sends an 8-bit command byte, a 16-bit data field, two reserved bits that must be zero and a 6-bit CRC. The block oversamples the serial pins with its own system clock. It counts the serial clock edges in each frame and checks the CRC. It then either performs a register write or fetches a register value for a read.

Every frame is answered one frame later. While the host shifts in its next command, the block shifts out a word with four parts: the previous command byte, the register data that belongs to it, a 2-bit status code that says whether the previous frame arrived intact, and a fresh CRC over the upper 24 bits. A damaged frame changes no register. It is reported in the status field of the next response, and it also sets a sticky fault output that stays set until the host clears it through a dedicated input.

Top module: `spi_crc_regslave`

## Requirements
- R1: A frame is the span while `ncs` is low. It must contain exactly 32 rising `sclk` edges. `sdi` is sampled on each rising edge, most significant bit first. Bits 31:24 are the command byte, bits 23:8 the data, bits 7:6 reserved and bits 5:0 the CRC.
- R2: The CRC is 6 bits wide with polynomial x^6+x^4+x^3+x+1 (low terms 0x1B). It uses seed 0x3F, is processed MSB first, and covers frame bits 31:8. With these settings the command 0x5300000B carries a valid CRC.
- R3: A command byte with bit 7 set is a write. After a valid write frame, `regWrEn` pulses for one `clk` cycle after `ncs` rises. During that pulse, `regAddr` carries command bits 6:0 and `regWrData` carries frame bits 23:8.
- R4: A command byte with bit 7 clear is a read of register index bits 6:0. The response in the next frame is {command byte, register contents, status 00, CRC of the upper 24 bits}.
- R5: The response to a valid write echoes the command byte and the data just written, with status 00.
- R6: The data field of a read command is ignored. Any value is accepted if the CRC over it is correct.
- R7: A frame is invalid if any of these holds: its edge count is not 32, its CRC is wrong, or its reserved bits are not 00. An invalid frame writes no register. The next response carries upper 24 bits of zero and status 01 in bits 7:6.
- R8: The status returns to 00 in the response that follows one correctly received frame.
- R9: `spiFault` is set by any invalid frame and stays set until `faultClr` is asserted. A new error has priority over a clear in the same cycle.
- R10: `sdoOe` is high while `ncs` is low and drops after `ncs` rises. Response bit 31 is on `sdo` before the first rising `sclk` edge, and each later bit follows a falling `sclk` edge.
- R11: After reset, `spiFault`, `regWrEn` and `sdoOe` are low. The first response carries upper 24 bits of zero, status 00 and the matching CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| ncs | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial response data |
| sdoOe | output | 1 | Output enable for the `sdo` pad; the pad floats when it is low |
| regAddr | output | 7 | Register index taken from the command byte |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 16 | Register write data |
| regRdData | input | 16 | Combinational read data for `regAddr` |
| faultClr | input | 1 | Clears the sticky fault flag |
| spiFault | output | 1 | Sticky flag for any invalid frame |

## Verification
The bench builds the block with its default settings: CRC polynomial 0x1B, seed 0x3F and two synchronizer stages. With these settings the known command 0x5300000B must be accepted as valid, so one fixed vector ties the CRC defaults to the expected check value. The serial clock runs at six system clocks per half period. This leaves room for the synchronizer delay, so the bench can sample `sdo` the way a real host would, just before each rising edge. Frames of 31 and 33 edges, a flipped CRC bit and nonzero reserved bits all exercise the error path. Each is followed by reads that show the status, the sticky fault and the register contents.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;

  localparam int FRAME_W = 32;
  localparam int CRC_W   = 6;
  localparam int HDR_W   = 24;
  localparam int DATA_W  = 16;
  localparam int IDX_W   = 7;

  typedef struct packed {
    logic frameStart;
    logic shiftIn;
    logic shiftOut;
    logic frameEnd;
    logic frameGood;
  } strobes_t;

  // MSB-first CRC over the upper 24 bits of a frame
  function automatic logic [CRC_W-1:0] crc6Calc(
    input logic [HDR_W-1:0] hdr,
    input logic [CRC_W-1:0] poly,
    input logic [CRC_W-1:0] seed
  );
    logic [CRC_W-1:0] acc;
    logic fb;
    acc = seed;
    for (int i = HDR_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ hdr[i];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ poly;
    end
    return acc;
  endfunction

endpackage

// File: rtl/spi_crc_ctrl.sv
module spi_crc_ctrl
  import spi_crc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclkPin,
  input  logic     ncsPin,
  input  logic     sdiPin,
  input  logic     crcOk,
  input  logic     rsvdOk,
  input  logic     isWrite,
  input  logic     faultClr,
  output strobes_t strb,
  output logic     sdiSync,
  output logic     ncsSync,
  output logic     regWrEn,
  output logic     spiFault
);

  localparam int CNT_W = $clog2(FRAME_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] sclkPipe, ncsPipe, sdiPipe;
  logic sclkSync, sclkPrev, ncsPrev;
  logic [CNT_W-1:0] bitCnt;

  // pin synchronizers, one chain per pin
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkPipe <= '0;
          ncsPipe  <= '1;
          sdiPipe  <= '0;
        end else begin
          sclkPipe <= sclkPin;
          ncsPipe  <= ncsPin;
          sdiPipe  <= sdiPin;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkPipe <= '0;
          ncsPipe  <= '1;
          sdiPipe  <= '0;
        end else begin
          sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkPin};
          ncsPipe  <= {ncsPipe[SYNC_STAGES-2:0], ncsPin};
          sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdiPin};
        end
      end
    end
  endgenerate

  assign sclkSync = sclkPipe[SYNC_STAGES-1];
  assign ncsSync  = ncsPipe[SYNC_STAGES-1];
  assign sdiSync  = sdiPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      ncsPrev  <= 1'b1;
    end else begin
      sclkPrev <= sclkSync;
      ncsPrev  <= ncsSync;
    end
  end

  // edge strobes towards the datapath
  always_comb begin
    strb.frameStart = !ncsSync && ncsPrev;
    strb.frameEnd   = ncsSync && !ncsPrev;
    strb.shiftIn    = !ncsSync && sclkSync && !sclkPrev;
    strb.shiftOut   = !ncsSync && !sclkSync && sclkPrev;
    strb.frameGood  = (bitCnt == CNT_GOOD) && crcOk && rsvdOk;
  end

  // rising-edge counter, saturating so long frames stay invalid
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strb.frameStart) begin
      bitCnt <= '0;
    end else if (strb.shiftIn && bitCnt != CNT_MAX) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWrEn <= 1'b0;
    end else begin
      regWrEn <= strb.frameEnd && strb.frameGood && isWrite;
    end
  end

  // sticky fault, a new error outranks a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spiFault <= 1'b0;
    end else if (strb.frameEnd && !strb.frameGood) begin
      spiFault <= 1'b1;
    end else if (faultClr) begin
      spiFault <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_crc_dp.sv
module spi_crc_dp
  import spi_crc_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 6'h1B,
  parameter logic [CRC_W-1:0] CRC_SEED = 6'h3F
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic              sdiSync,
  input  logic [DATA_W-1:0] regRdData,
  output logic              sdoBit,
  output logic              crcOk,
  output logic              rsvdOk,
  output logic              isWrite,
  output logic [IDX_W-1:0]  regIdx,
  output logic [DATA_W-1:0] regWrData,
  output logic              respErr
);

  logic [FRAME_W-1:0] rxShift, txShift, txWord;
  logic [HDR_W-1:0]   respHdr;
  logic [CRC_W-1:0]   rxCrcExp, txCrc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strb.shiftIn) begin
      rxShift <= {rxShift[FRAME_W-2:0], sdiSync};
    end
  end

  assign rxCrcExp  = crc6Calc(rxShift[FRAME_W-1:CRC_W+2], CRC_POLY, CRC_SEED);
  assign crcOk     = (rxCrcExp == rxShift[CRC_W-1:0]);
  assign rsvdOk    = (rxShift[CRC_W+1:CRC_W] == 2'b00);
  assign isWrite   = rxShift[FRAME_W-1];
  assign regIdx    = rxShift[FRAME_W-2:FRAME_W-1-IDX_W];
  assign regWrData = rxShift[FRAME_W-9:CRC_W+2];

  // response word latched when a frame closes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respHdr <= '0;
      respErr <= 1'b0;
    end else if (strb.frameEnd) begin
      if (strb.frameGood) begin
        respHdr <= {rxShift[FRAME_W-1:FRAME_W-8],
                    isWrite ? regWrData : regRdData};
        respErr <= 1'b0;
      end else begin
        respHdr <= '0;
        respErr <= 1'b1;
      end
    end
  end

  assign txCrc  = crc6Calc(respHdr, CRC_POLY, CRC_SEED);
  assign txWord = {respHdr, 1'b0, respErr, txCrc};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strb.frameStart) begin
      txShift <= txWord;
    end else if (strb.shiftOut) begin
      txShift <= {txShift[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdoBit = txShift[FRAME_W-1];

endmodule

// File: rtl/spi_crc_regslave.sv
module spi_crc_regslave
  import spi_crc_pkg::*;
#(
  parameter logic [5:0] CRC_POLY    = 6'h1B,
  parameter logic [5:0] CRC_SEED    = 6'h3F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        ncs,
  input  logic        sdi,
  output logic        sdo,
  output logic        sdoOe,
  output logic [6:0]  regAddr,
  output logic        regWrEn,
  output logic [15:0] regWrData,
  input  logic [15:0] regRdData,
  input  logic        faultClr,
  output logic        spiFault
);

  strobes_t strb;
  logic sdiSync, ncsSync, crcOk, rsvdOk, isWrite, respErr;

  spi_crc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclkPin  (sclk),
    .ncsPin   (ncs),
    .sdiPin   (sdi),
    .crcOk    (crcOk),
    .rsvdOk   (rsvdOk),
    .isWrite  (isWrite),
    .faultClr (faultClr),
    .strb     (strb),
    .sdiSync  (sdiSync),
    .ncsSync  (ncsSync),
    .regWrEn  (regWrEn),
    .spiFault (spiFault)
  );

  spi_crc_dp #(.CRC_POLY(CRC_POLY), .CRC_SEED(CRC_SEED)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sdiSync   (sdiSync),
    .regRdData (regRdData),
    .sdoBit    (sdo),
    .crcOk     (crcOk),
    .rsvdOk    (rsvdOk),
    .isWrite   (isWrite),
    .regIdx    (regAddr),
    .regWrData (regWrData),
    .respErr   (respErr)
  );

  assign sdoOe = !ncsSync;

endmodule

// File: rtl/spi_crc_regslave_chk.sv
module spi_crc_regslave_chk (
  input logic clk,
  input logic rstN,
  input logic regWrEn,
  input logic sdoOe,
  input logic spiFault,
  input logic faultClr,
  input logic errStatus
);

  // R3
  wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R10
  wr_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !sdoOe);

  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiFault) |-> $past(faultClr));

  // R7
  fault_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiFault) |-> (errStatus && !regWrEn));

endmodule

bind spi_crc_regslave spi_crc_regslave_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .sdoOe     (sdoOe),
  .spiFault  (spiFault),
  .faultClr  (faultClr),
  .errStatus (respErr)
);

// File: tb/sim_spi_crc_regslave.sv
module sim_spi_crc_regslave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, ncs = 1'b1, sdi = 1'b0, faultClr = 1'b0;
  logic sdo, sdoOe, regWrEn, spiFault;
  logic [6:0]  regAddr;
  logic [15:0] regWrData, regRdData;
  logic [15:0] mem [128];
  int checks = 0, errors = 0;
  logic [31:0] rsp;
  logic oeSeen;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_crc_regslave u0 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .ncs(ncs), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .faultClr(faultClr), .spiFault(spiFault)
  );

  assign regRdData = mem[regAddr];
  always @(posedge clk) if (regWrEn) mem[regAddr] <= regWrData;

  function automatic logic [5:0] refCrc(input logic [23:0] d);
    logic [5:0] r = 6'h3F;
    for (int i = 23; i >= 0; i--) begin
      logic top = r[5] ^ d[i];
      r = {r[4:0], 1'b0} ^ (top ? 6'h1B : 6'h00);
    end
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] cmd, input logic [15:0] dat);
    return {cmd, dat, 2'b00, refCrc({cmd, dat})};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic checkRsp(input string req, input logic [23:0] hdr, input logic [1:0] st);
    check(req, rsp, {hdr, st, refCrc(hdr)});
  endtask

  // one frame with nClk rising edges; captures the response into rsp
  task automatic xfer(input logic [31:0] w, input int nClk);
    rsp = '0;
    oeSeen = 1'b1;
    @(negedge clk) ncs = 1'b0;
    repeat (2*HALF) @(negedge clk);
    for (int i = 0; i < nClk; i++) begin
      sdi = (i < 32) ? w[31-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 32) rsp[31-i] = sdo;
      if (!sdoOe) oeSeen = 1'b0;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    ncs = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic clearFault();
    @(negedge clk) faultClr = 1'b1;
    @(negedge clk) faultClr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic tResetState();
    repeat (3) @(negedge clk);
    check("R11 fault", {31'd0, spiFault}, 32'd0);
    check("R11 wren", {31'd0, regWrEn}, 32'd0);
    check("R11 oe", {31'd0, sdoOe}, 32'd0);
  endtask

  task automatic tReads();
    xfer(32'h5300000B, 32);
    checkRsp("R11 first response", 24'h0, 2'b00);
    check("R10 oe during frame", {31'd0, oeSeen}, 32'd1);
    check("R10 oe released", {31'd0, sdoOe}, 32'd0);
    xfer(mk(8'h53, 16'h00F0), 32);
    checkRsp("R2 R4 read 0x53", 24'h538B40, 2'b00);
    xfer(mk(8'h21, 16'hFFFF), 32);
    checkRsp("R6 dummy data read", 24'h538B40, 2'b00);
    xfer(mk(8'h53, 16'h0000), 32);
    checkRsp("R4 read 0x21", {8'h21, mem[7'h21]}, 2'b00);
  endtask

  task automatic tWrite();
    xfer(mk(8'h92, 16'hBEEF), 32);
    xfer(mk(8'h12, 16'h0000), 32);
    checkRsp("R5 write echo", 24'h92BEEF, 2'b00);
    check("R3 register written", {16'd0, mem[7'h12]}, 32'h0000BEEF);
    xfer(mk(8'h12, 16'h0000), 32);
    checkRsp("R3 readback", 24'h12BEEF, 2'b00);
  endtask

  task automatic tBadCrc();
    xfer(mk(8'h92, 16'h1111) ^ 32'h1, 32);
    checkRsp("R4 prior read", 24'h12BEEF, 2'b00);
    check("R9 fault set", {31'd0, spiFault}, 32'd1);
    xfer(mk(8'h12, 16'h0000), 32);
    checkRsp("R7 bad crc status", 24'h0, 2'b01);
    xfer(mk(8'h12, 16'h0000), 32);
    checkRsp("R7 R8 no write, status cleared", 24'h12BEEF, 2'b00);
    check("R9 fault sticky", {31'd0, spiFault}, 32'd1);
    clearFault();
    check("R9 fault cleared", {31'd0, spiFault}, 32'd0);
  endtask

  task automatic tCount(input int n);
    xfer(mk(8'h92, 16'h2222), n);
    xfer(mk(8'h12, 16'h0000), 32);
    checkRsp($sformatf("R1 R7 %0d edges", n), 24'h0, 2'b01);
    xfer(mk(8'h12, 16'h0000), 32);
    checkRsp("R7 R8 count no write", 24'h12BEEF, 2'b00);
    check("R9 fault on count", {31'd0, spiFault}, 32'd1);
    clearFault();
  endtask

  task automatic tReserved();
    xfer(mk(8'h92, 16'h3333) | 32'h40, 32);
    xfer(mk(8'h12, 16'h0000), 32);
    checkRsp("R7 reserved bits", 24'h0, 2'b01);
    xfer(mk(8'h12, 16'h0000), 32);
    checkRsp("R7 reserved no write", 24'h12BEEF, 2'b00);
    clearFault();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'(i * 16'h0301) ^ 16'h5A5A;
    mem[7'h53] = 16'h8B40;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    tResetState();
    tReads();
    tWrite();
    tBadCrc();
    tCount(31);
    tCount(33);
    tReserved();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule